// File: doc/BRIEF.md
# Shift and Increment Flag Unit

This block is the single-cycle execution slice of an 8-bit processor core that handles increment, decrement and multi-bit shifts on either a byte or a 16-bit word. Each clock it takes an operation code, a size select, a 16-bit operand, a shift count and the present zero, auxiliary-carry and carry flags. One clock later it presents the result, the next value of each flag, and a write enable per flag. The flag register of the core writes only the enabled flags, so each operation touches exactly its own subset of flags.

Shifts are computed in one pass by a logarithmic barrel shifter. The outcome equals repeating a one-place shift count times. Across a multi-bit shift, carry holds the last bit that left the operand. Operand fetch, addressing, memory access, the register file and decode lie outside the block.

Top module: `sif_unit`

## Requirements
- R1: Operation code `op_i` is 0 none, 1 increment, 2 decrement, 3 logical right shift, 4 left shift, 5 arithmetic right shift. `word_i`=1 selects 16-bit size and 0 selects byte size. All outputs are registered and reflect the inputs of the previous clock edge. Synchronous reset clears every output to 0.
- R2: Byte increment gives `res_o[7:0]` = operand[7:0]+1 modulo 256. Zero is set when that byte is 0. Auxiliary carry is set when operand[3:0] was 0xF. The zero and auxiliary-carry enables are 1, the carry enable is 0, and `cy_o` equals the carry input.
- R3: Byte decrement gives `res_o[7:0]` = operand[7:0]-1 modulo 256. Zero is set when that byte is 0. Auxiliary carry is set when operand[3:0] was 0x0. Enables and carry behave as in R2.
- R4: Word increment and decrement wrap modulo 65536. All three enables are 0, and every flag output equals its input.
- R5: Logical right shift repeats count times: carry takes bit 0, bits move down one place, and the top bit receives 0.
- R6: Left shift repeats count times: carry takes the top bit (bit 7 for byte, bit 15 for word), bits move up one place, and bit 0 receives 0.
- R7: Arithmetic right shift repeats count times: carry takes bit 0, bits move down one place, and the top bit keeps its previous value.
- R8: Every shift sets the carry enable to 1 and the zero and auxiliary-carry enables to 0. `z_o` and `ac_o` equal their inputs.
- R9: The effective count is `cnt_i[2:0]` for byte size and `cnt_i[3:0]` for word size. An effective count of 0 returns the sized operand unchanged, and `cy_o` equals the carry input.
- R10: Byte operations (increment, decrement and shifts) use only operand[7:0] and drive `res_o[15:8]` to 0.
- R11: Op codes 0, 6 and 7 give a zero result, all enables 0, and flag outputs equal to their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| word_i | input | 1 | 1 = 16-bit size, 0 = byte size |
| opnd_i | input | 16 | Operand |
| cnt_i | input | 4 | Shift count |
| z_i | input | 1 | Current zero flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| cy_i | input | 1 | Current carry flag |
| res_o | output | 16 | Result |
| z_o | output | 1 | Next zero flag |
| ac_o | output | 1 | Next auxiliary-carry flag |
| cy_o | output | 1 | Next carry flag |
| z_we_o | output | 1 | Zero flag write enable |
| ac_we_o | output | 1 | Auxiliary-carry write enable |
| cy_we_o | output | 1 | Carry write enable |

## Verification
The assertions compare the registered outputs against inputs sampled one cycle earlier, and they fire only when that earlier cycle was outside reset. They take for granted that every input is a known value on each rising edge, including the unused op codes 6 and 7 and byte-size counts above 7. The stimulus changes inputs only on falling edges and always drives defined values. Directed cases and random vectors across every op code, size, count and flag combination, among them the undefined codes and the masked counts, keep all of it inside those assumptions.

// File: rtl/sif_pkg.sv
package sif_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int BCNT_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_INC  = 3'd1,
        OP_DEC  = 3'd2,
        OP_SHR  = 3'd3,
        OP_SHL  = 3'd4,
        OP_SAR  = 3'd5
    } sif_op_e;

    typedef struct packed {
        logic z;
        logic ac;
        logic cy;
    } sif_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        sif_flags_t        flg;
        sif_flags_t        we;
    } sif_out_t;

    function automatic logic is_shift(input logic [2:0] op);
        return (op == OP_SHR) || (op == OP_SHL) || (op == OP_SAR);
    endfunction

    function automatic logic is_step(input logic [2:0] op);
        return (op == OP_INC) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/sif_shifter.sv
module sif_shifter #(
    parameter int  W   = 8,
    localparam int STG = $clog2(W)
) (
    input  logic [W-1:0]   val_i,
    input  logic [STG-1:0] cnt_i,
    input  logic           left_i,
    input  logic           arith_i,
    input  logic           cy_i,
    output logic [W-1:0]   val_o,
    output logic           cy_o
);

    logic [STG:0][W-1:0] stage_v;
    logic [STG:0]        stage_c;

    assign stage_v[0] = val_i;
    assign stage_c[0] = cy_i;

    for (genvar k = 0; k < STG; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [W-1:0] moved;
        logic         lost;
        logic         fill;

        assign fill  = arith_i & stage_v[k][W-1];
        assign moved = left_i ? (stage_v[k] << S)
                              : ((stage_v[k] >> S) | ({W{fill}} << (W - S)));
        assign lost  = left_i ? stage_v[k][W-S] : stage_v[k][S-1];

        assign stage_v[k+1] = cnt_i[k] ? moved : stage_v[k];
        assign stage_c[k+1] = cnt_i[k] ? lost  : stage_c[k];
    end

    assign val_o = stage_v[STG];
    assign cy_o  = stage_c[STG];

endmodule

// File: rtl/sif_incdec.sv
module sif_incdec
    import sif_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic              word_i,
    input  logic              dec_i,
    output logic [DATA_W-1:0] res_o,
    output logic              z_o,
    output logic              ac_o
);

    logic [BYTE_W-1:0] lo;
    logic [DATA_W-1:0] full;

    always_comb begin
        lo    = dec_i ? (a_i[BYTE_W-1:0] - 1'b1) : (a_i[BYTE_W-1:0] + 1'b1);
        full  = dec_i ? (a_i - 1'b1) : (a_i + 1'b1);
        res_o = word_i ? full : {{(DATA_W-BYTE_W){1'b0}}, lo};
        z_o   = (lo == '0);
        ac_o  = dec_i ? (a_i[NIB_W-1:0] == '0) : (a_i[NIB_W-1:0] == '1);
    end

endmodule

// File: rtl/sif_unit.sv
module sif_unit
    import sif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic              word_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              z_i,
    input  logic              ac_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] res_o,
    output logic              z_o,
    output logic              ac_o,
    output logic              cy_o,
    output logic              z_we_o,
    output logic              ac_we_o,
    output logic              cy_we_o
);

    logic              left, arith;
    logic [BYTE_W-1:0] b_val;
    logic              b_cy;
    logic [DATA_W-1:0] w_val;
    logic              w_cy;
    logic [DATA_W-1:0] step_res;
    logic              step_z, step_ac;
    sif_out_t          nxt, cur;
    sif_flags_t        fin;

    assign left  = (op_i == OP_SHL);
    assign arith = (op_i == OP_SAR);
    assign fin   = '{z: z_i, ac: ac_i, cy: cy_i};

    sif_shifter #(.W(BYTE_W)) u_bshift (
        .val_i  (opnd_i[BYTE_W-1:0]),
        .cnt_i  (cnt_i[BCNT_W-1:0]),
        .left_i (left),
        .arith_i(arith),
        .cy_i   (cy_i),
        .val_o  (b_val),
        .cy_o   (b_cy)
    );

    sif_shifter #(.W(DATA_W)) u_wshift (
        .val_i  (opnd_i),
        .cnt_i  (cnt_i),
        .left_i (left),
        .arith_i(arith),
        .cy_i   (cy_i),
        .val_o  (w_val),
        .cy_o   (w_cy)
    );

    sif_incdec u_step (
        .a_i   (opnd_i),
        .word_i(word_i),
        .dec_i (op_i == OP_DEC),
        .res_o (step_res),
        .z_o   (step_z),
        .ac_o  (step_ac)
    );

    always_comb begin
        nxt     = '0;
        nxt.flg = fin;
        if (is_step(op_i)) begin
            nxt.res = step_res;
            if (!word_i) begin
                nxt.flg.z  = step_z;
                nxt.flg.ac = step_ac;
                nxt.we.z   = 1'b1;
                nxt.we.ac  = 1'b1;
            end
        end else if (is_shift(op_i)) begin
            nxt.we.cy = 1'b1;
            if (word_i) begin
                nxt.res    = w_val;
                nxt.flg.cy = w_cy;
            end else begin
                nxt.res    = {{(DATA_W-BYTE_W){1'b0}}, b_val};
                nxt.flg.cy = b_cy;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign res_o   = cur.res;
    assign z_o     = cur.flg.z;
    assign ac_o    = cur.flg.ac;
    assign cy_o    = cur.flg.cy;
    assign z_we_o  = cur.we.z;
    assign ac_we_o = cur.we.ac;
    assign cy_we_o = cur.we.cy;

    assert_byte_step_flags_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && is_step(op_i) && !word_i) |=>
            (z_we_o && ac_we_o && !cy_we_o && cy_o == $past(cy_i)
             && res_o[DATA_W-1:BYTE_W] == '0));

    assert_word_step_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && is_step(op_i) && word_i) |=>
            (!z_we_o && !ac_we_o && !cy_we_o
             && z_o == $past(z_i) && ac_o == $past(ac_i) && cy_o == $past(cy_i)));

    assert_shift_carry_only_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && is_shift(op_i)) |=>
            (cy_we_o && !z_we_o && !ac_we_o
             && z_o == $past(z_i) && ac_o == $past(ac_i)));

    assert_zero_count_R9: assert property (@(posedge clk) disable iff (rst)
        (!rst && is_shift(op_i) && word_i && cnt_i == '0) |=>
            (res_o == $past(opnd_i) && cy_o == $past(cy_i)));

    assert_idle_code_R11: assert property (@(posedge clk) disable iff (rst)
        (!rst && !is_shift(op_i) && !is_step(op_i)) |=>
            (res_o == '0 && !z_we_o && !ac_we_o && !cy_we_o));

    assert_enable_subset_R1: assert property (@(posedge clk) disable iff (rst)
        !(cy_we_o && (z_we_o || ac_we_o)));

endmodule

// File: tb/sif_unit_test.sv
`timescale 1ns/1ps
module sif_unit_test;

    localparam int K_NONE = 0, K_INC = 1, K_DEC = 2, K_SHR = 3, K_SHL = 4, K_SAR = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = '0;
    logic        word_i = 1'b0;
    logic [15:0] opnd_i = '0;
    logic [3:0]  cnt_i = '0;
    logic        z_i = 1'b0, ac_i = 1'b0, cy_i = 1'b0;
    logic [15:0] res_o;
    logic        z_o, ac_o, cy_o, z_we_o, ac_we_o, cy_we_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sif_unit uut (
        .clk(clk), .rst(rst), .op_i(op_i), .word_i(word_i), .opnd_i(opnd_i),
        .cnt_i(cnt_i), .z_i(z_i), .ac_i(ac_i), .cy_i(cy_i), .res_o(res_o),
        .z_o(z_o), .ac_o(ac_o), .cy_o(cy_o), .z_we_o(z_we_o),
        .ac_we_o(ac_we_o), .cy_we_o(cy_we_o)
    );

    task automatic ck(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Bit-serial reference: each shift is repeated one place at a time.
    task automatic apply(input int op, input int wd, input int a, input int cnt,
                         input int zi, input int aci, input int cyi);
        int w, mask, n, v, r, ez, eac, ecy, wz, wac, wcy;
        string tag;
        w = wd ? 16 : 8;
        mask = (1 << w) - 1;
        n = wd ? (cnt & 15) : (cnt & 7);
        r = 0; ez = zi; eac = aci; ecy = cyi; wz = 0; wac = 0; wcy = 0;
        tag = "R11";
        if (op == K_INC || op == K_DEC) begin
            if (op == K_INC) r = (a + 1) & mask;
            else             r = (a - 1) & mask;
            if (wd) tag = "R4";
            else begin
                tag = (op == K_INC) ? "R2" : "R3";
                ez  = (r == 0);
                eac = (op == K_INC) ? ((a & 15) == 15) : ((a & 15) == 0);
                wz = 1; wac = 1;
            end
        end else if (op == K_SHR || op == K_SHL || op == K_SAR) begin
            v = a & mask;
            for (int i = 0; i < n; i++) begin
                int top;
                top = (v >> (w - 1)) & 1;
                if (op == K_SHL) begin
                    ecy = top;
                    v = (v << 1) & mask;
                end else begin
                    ecy = v & 1;
                    v = v >> 1;
                    if (op == K_SAR) v = v | (top << (w - 1));
                end
            end
            r = v; wcy = 1;
            tag = (n == 0) ? "R9" : (op == K_SHR) ? "R5" : (op == K_SHL) ? "R6" : "R7";
        end
        op_i = op[2:0]; word_i = wd[0]; opnd_i = a[15:0]; cnt_i = cnt[3:0];
        z_i = zi[0]; ac_i = aci[0]; cy_i = cyi[0];
        @(negedge clk);
        ck(tag, "result", int'(res_o), r);
        if (!wd && (op >= K_INC && op <= K_SAR)) ck("R10", "upper byte", int'(res_o[15:8]), 0);
        ck(tag, "carry", int'(cy_o), ecy);
        ck(tag, "carry enable", int'(cy_we_o), wcy);
        ck((wcy != 0) ? "R8" : tag, "zero", int'(z_o), ez);
        ck((wcy != 0) ? "R8" : tag, "aux carry", int'(ac_o), eac);
        ck((wcy != 0) ? "R8" : tag, "zero enable", int'(z_we_o), wz);
        ck((wcy != 0) ? "R8" : tag, "aux enable", int'(ac_we_o), wac);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        op_i = 3'd1; opnd_i = 16'h00FF; z_i = 1; ac_i = 1; cy_i = 1;
        repeat (3) @(negedge clk);
        ck("R1", "reset result", int'(res_o), 0);
        ck("R1", "reset flags", int'({z_o, ac_o, cy_o, z_we_o, ac_we_o, cy_we_o}), 0);
        rst = 1'b0;
        // directed corners
        apply(K_INC, 0, 16'h00FF, 0, 0, 0, 1);   // R2 wrap to zero, aux carry
        apply(K_INC, 0, 16'hAB0F, 0, 1, 0, 0);   // R2 R10 upper byte ignored
        apply(K_INC, 0, 16'h0010, 0, 1, 1, 1);
        apply(K_DEC, 0, 16'h0000, 0, 1, 0, 0);   // R3 borrow wrap
        apply(K_DEC, 0, 16'h0001, 0, 0, 0, 1);   // R3 zero
        apply(K_INC, 1, 16'hFFFF, 0, 0, 1, 0);   // R4
        apply(K_DEC, 1, 16'h0000, 0, 1, 0, 1);   // R4
        apply(K_SHR, 0, 16'h0081, 1, 1, 1, 0);   // R5
        apply(K_SHR, 0, 16'h00C0, 7, 0, 0, 1);
        apply(K_SHL, 1, 16'h8001, 15, 1, 0, 0);  // R6
        apply(K_SHL, 0, 16'h0081, 1, 0, 1, 0);
        apply(K_SAR, 0, 16'h0080, 7, 0, 0, 1);   // R7
        apply(K_SAR, 1, 16'h8003, 2, 1, 1, 0);
        apply(K_SHR, 0, 16'h12F5, 0, 0, 1, 1);   // R9 zero count
        apply(K_SHL, 1, 16'h9876, 0, 1, 0, 0);   // R9
        apply(K_SHL, 0, 16'h0003, 9, 0, 0, 0);   // R9 byte count masked to 1
        apply(K_NONE, 0, 16'h1234, 3, 1, 1, 1);  // R11
        apply(6, 1, 16'hFFFF, 5, 0, 1, 0);       // R11
        apply(7, 0, 16'h00FF, 1, 1, 0, 1);       // R11
        for (int i = 0; i < 4000; i++) begin
            apply($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 65535),
                  $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, 1));
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule